// File: doc/BRIEF.md
# Bit-Sliced Repeated-Addition Multiplier Datapath

This block is the arithmetic half of an 8-bit multiplier that works by repeated addition. It is built from identical bit slices. Each slice holds one bit of four registers: an accumulator, a multiplicand register, a down-counter and a result register. It also holds one full-adder stage of a ripple adder, one half-subtractor stage of a ripple decrementer, and the local bus logic. Carry, borrow and scan links pass between neighbouring slices only. The block has no sequencer of its own. An external controller drives the load strobes and the bus-driver selects every cycle. To form a product, the controller clears the accumulator and loads the multiplicand and the count. It then decrements the count and adds the multiplicand into the accumulator together, until the underflow flag reports a zero count. Last, it clears the multiplicand and copies the sum into the result register.

A single shared bus feeds the accumulator, the multiplicand and the result register. It carries one of three sources: the first operand, all zeros, or the adder sum. The counter has its own source select, either the second operand or the decrementer output. All 32 register bits form one scan chain. While scan mode is high, every bit moves one place along the chain on each clock, and all parallel loads are ignored.

The block has no state machine, so there are no states or transitions to list. Its behaviour is fixed entirely by the strobe values in each cycle.

Top module: `rpt_mul_datapath`

## Requirements
- R1: An active-low reset clears all four registers asynchronously, without waiting for a clock edge. While reset is low, the result reads 0x00 and the underflow flag reads 1.
- R2: When scan mode is low and the count load strobe is high with the count source select high, the counter takes the second operand at the rising edge.
- R3: When scan mode is low and the count load strobe is high with the count source select low, the counter takes its own value minus one, modulo 256. A count of 0x00 becomes 0xFF.
- R4: The underflow flag is the borrow out of the decrementer. It is 1 exactly when the counter holds 0x00, and it follows the counter with no added register delay.
- R5: When scan mode is low, the accumulator, multiplicand and result registers each load the bus when their own load strobe is high. The bus carries the first operand when the operand driver is high. It carries 0x00 when the zero driver is high. It carries (accumulator + multiplicand) modulo 256 when the sum driver is high.
- R6: A register whose load strobe is low keeps its value, whatever the bus, operand and select inputs are doing.
- R7: When scan mode is high, all 32 bits shift one place per rising edge, and every load strobe is ignored. Chain position 0 takes the scan input. Positions 0–7 hold accumulator bits 0–7. Positions 8–15 hold multiplicand bits 0–7. Positions 16–23 hold counter bits 0–7. Positions 24–31 hold result bits 0–7.
- R8: The scan output always equals bit 7 of the result register, the last position in the chain, in both scan mode and normal mode.
- R9: The repeated-addition sequence gives the product of the two operands modulo 256 on the result port. The sequence is: clear the accumulator; load the multiplicand and the count; while underflow is 0, decrement and add into the accumulator in the same cycle; clear the multiplicand; copy the sum into the result register. The loop runs exactly as many times as the second operand.
- R10: When none of the three bus drivers is high, the bus carries 0x00. A register loaded in that cycle becomes 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Scan mode: shift the whole chain |
| scan_in | input | 1 | Serial input to chain position 0 |
| ld_acc | input | 1 | Accumulator load strobe |
| ld_mcand | input | 1 | Multiplicand load strobe |
| ld_count | input | 1 | Counter load strobe |
| ld_res | input | 1 | Result register load strobe |
| drv_sum | input | 1 | Put the adder sum on the bus |
| drv_zero | input | 1 | Put all zeros on the bus |
| drv_opa | input | 1 | Put the first operand on the bus |
| count_sel_op | input | 1 | Counter source: 1 = second operand, 0 = decrementer |
| opa | input | 8 | First operand (multiplicand) |
| opb | input | 8 | Second operand (count) |
| scan_out | output | 1 | Serial output from chain position 31 |
| result | output | 8 | Result register contents |
| count_underflow | output | 1 | Decrementer borrow-out; high when the counter is zero |

## Verification
The bench decrements the counter through 0x00. A decrementer with a broken borrow chain would stop at zero or wrap to a wrong value, and an inverted flag would end the multiply loop at once or never. It loads the chain through scan with every load strobe held high and then reads back each field position. A mis-ordered chain would put the result byte in the wrong register, and a load that overrides scan would corrupt the pattern. It drives sums that overflow 8 bits, a cycle with no bus driver, and a reset pulse between clock edges. A design with a sticky carry, a floating bus default or a synchronous reset would each give a wrong result byte.

// File: rtl/rpt_mul_pkg.sv
package rpt_mul_pkg;

    // Number of registers carried in every bit slice.
    localparam int NUM_REGS = 4;

    // Slice-local register indices. The chain visits the registers in this
    // order, so these values decide where each field sits on the scan chain.
    localparam int IDX_ACC   = 0;
    localparam int IDX_MCAND = 1;
    localparam int IDX_COUNT = 2;
    localparam int IDX_RES   = 3;

endpackage

// File: rtl/rpt_mul_scan_cell.sv
module rpt_mul_scan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_en,
    input  logic scan_in,
    input  logic load,
    input  logic d,
    output logic q
);

    // Scan mode takes priority over the parallel load.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (scan_en) begin
            q <= scan_in;
        end else if (load) begin
            q <= d;
        end
    end

    p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (q == $past(scan_in)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !load) |=> (q == $past(q)));

endmodule

// File: rtl/rpt_mul_full_add.sv
module rpt_mul_full_add (
    input  logic a,
    input  logic b,
    input  logic cin,
    output logic s,
    output logic cout
);

    logic ab_x;

    always_comb begin
        ab_x = a ^ b;
        s    = ab_x ^ cin;
        cout = (a & b) | (ab_x & cin);
    end

endmodule

// File: rtl/rpt_mul_half_sub.sv
module rpt_mul_half_sub (
    input  logic x,
    input  logic bin,
    output logic diff,
    output logic bout
);

    // A half adder fed with the inverted minuend; its sum is inverted back.
    logic x_n;
    logic ha_sum;
    logic ha_carry;

    always_comb begin
        x_n      = ~x;
        ha_sum   = x_n ^ bin;
        ha_carry = x_n & bin;
        diff     = ~ha_sum;
        bout     = ha_carry;
    end

endmodule

// File: rtl/rpt_mul_slice.sv
module rpt_mul_slice
    import rpt_mul_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scan_en,
    input  logic [NUM_REGS-1:0] reg_load,
    input  logic                drv_sum,
    input  logic                drv_zero,
    input  logic                drv_opa,
    input  logic                count_sel_op,
    input  logic                opa_bit,
    input  logic                opb_bit,
    input  logic                carry_in,
    input  logic                borrow_in,
    input  logic [NUM_REGS-1:0] chain_in,
    output logic [NUM_REGS-1:0] chain_out,
    output logic [NUM_REGS-1:0] q_bits,
    output logic                carry_out,
    output logic                borrow_out,
    output logic                sum_bit
);

    logic                diff_bit;
    logic                bus_bit;
    logic [NUM_REGS-1:0] d_bits;

    rpt_mul_full_add u_add (
        .a    (q_bits[IDX_ACC]),
        .b    (q_bits[IDX_MCAND]),
        .cin  (carry_in),
        .s    (sum_bit),
        .cout (carry_out)
    );

    rpt_mul_half_sub u_dec (
        .x    (q_bits[IDX_COUNT]),
        .bin  (borrow_in),
        .diff (diff_bit),
        .bout (borrow_out)
    );

    // AND-OR bus. The zero driver clamps the bus low, and with no driver
    // active the bus also reads low.
    always_comb begin
        bus_bit = ~drv_zero & ((drv_opa & opa_bit) | (drv_sum & sum_bit));
        d_bits            = '0;
        d_bits[IDX_ACC]   = bus_bit;
        d_bits[IDX_MCAND] = bus_bit;
        d_bits[IDX_RES]   = bus_bit;
        d_bits[IDX_COUNT] = count_sel_op ? opb_bit : diff_bit;
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        rpt_mul_scan_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .scan_en (scan_en),
            .scan_in (chain_in[r]),
            .load    (reg_load[r]),
            .d       (d_bits[r]),
            .q       (q_bits[r])
        );
        assign chain_out[r] = q_bits[r];
    end

endmodule

// File: rtl/rpt_mul_datapath.sv
module rpt_mul_datapath
    import rpt_mul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_en,
    input  logic             scan_in,
    input  logic             ld_acc,
    input  logic             ld_mcand,
    input  logic             ld_count,
    input  logic             ld_res,
    input  logic             drv_sum,
    input  logic             drv_zero,
    input  logic             drv_opa,
    input  logic             count_sel_op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic             scan_out,
    output logic [WIDTH-1:0] result,
    output logic             count_underflow
);

    localparam int               CHAIN_LEN = NUM_REGS * WIDTH;
    localparam logic [WIDTH-1:0] ONE_V     = WIDTH'(1);

    logic [NUM_REGS-1:0] reg_load;
    logic [WIDTH:0]      carry;
    logic [WIDTH:0]      borrow;
    logic [CHAIN_LEN:0]  link;
    logic [WIDTH-1:0]    acc_q;
    logic [WIDTH-1:0]    mcand_q;
    logic [WIDTH-1:0]    count_q;
    logic [WIDTH-1:0]    res_q;
    logic [WIDTH-1:0]    sum_vec;

    always_comb begin
        reg_load            = '0;
        reg_load[IDX_ACC]   = ld_acc;
        reg_load[IDX_MCAND] = ld_mcand;
        reg_load[IDX_COUNT] = ld_count;
        reg_load[IDX_RES]   = ld_res;
    end

    assign carry[0]  = 1'b0;
    assign borrow[0] = 1'b1;
    assign link[0]   = scan_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic [NUM_REGS-1:0] s_in;
        logic [NUM_REGS-1:0] s_out;
        logic [NUM_REGS-1:0] s_q;

        // Register r, bit i sits at chain position r*WIDTH + i.
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_link
            assign s_in[r]                = link[r*WIDTH + i];
            assign link[r*WIDTH + i + 1]  = s_out[r];
        end

        rpt_mul_slice u_slice (
            .clk          (clk),
            .rst_n        (rst_n),
            .scan_en      (scan_en),
            .reg_load     (reg_load),
            .drv_sum      (drv_sum),
            .drv_zero     (drv_zero),
            .drv_opa      (drv_opa),
            .count_sel_op (count_sel_op),
            .opa_bit      (opa[i]),
            .opb_bit      (opb[i]),
            .carry_in     (carry[i]),
            .borrow_in    (borrow[i]),
            .chain_in     (s_in),
            .chain_out    (s_out),
            .q_bits       (s_q),
            .carry_out    (carry[i+1]),
            .borrow_out   (borrow[i+1]),
            .sum_bit      (sum_vec[i])
        );

        assign acc_q[i]   = s_q[IDX_ACC];
        assign mcand_q[i] = s_q[IDX_MCAND];
        assign count_q[i] = s_q[IDX_COUNT];
        assign res_q[i]   = s_q[IDX_RES];
    end

    assign result          = res_q;
    assign scan_out        = link[CHAIN_LEN];
    assign count_underflow = borrow[WIDTH];

    p_count_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && ld_count && count_sel_op) |=> (count_q == $past(opb)));

    p_count_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && ld_count && !count_sel_op) |=> (count_q == $past(count_q) - ONE_V));

    p_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count_underflow == (count_q == '0));

    p_adder_r5: assert property (@(posedge clk) disable iff (!rst_n)
        {carry[WIDTH], sum_vec} == ({1'b0, acc_q} + {1'b0, mcand_q}));

    p_one_driver_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drv_sum, drv_zero, drv_opa}));

    p_sum_to_res_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && ld_res && drv_sum) |=> (res_q == $past(acc_q) + $past(mcand_q)));

endmodule

// File: tb/rpt_mul_datapath_tb_top.sv
module rpt_mul_datapath_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scan_en, scan_in;
    logic       ld_acc, ld_mcand, ld_count, ld_res;
    logic       drv_sum, drv_zero, drv_opa, count_sel_op;
    logic [7:0] opa, opb;
    logic       scan_out;
    logic [7:0] result;
    logic       count_underflow;

    int checks = 0;
    int bad    = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rpt_mul_datapath #(.WIDTH(8)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .scan_en         (scan_en),
        .scan_in         (scan_in),
        .ld_acc          (ld_acc),
        .ld_mcand        (ld_mcand),
        .ld_count        (ld_count),
        .ld_res          (ld_res),
        .drv_sum         (drv_sum),
        .drv_zero        (drv_zero),
        .drv_opa         (drv_opa),
        .count_sel_op    (count_sel_op),
        .opa             (opa),
        .opb             (opb),
        .scan_out        (scan_out),
        .result          (result),
        .count_underflow (count_underflow)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Inputs change only at the falling edge; outputs are read there too.
    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        scan_en = 0; ld_acc = 0; ld_mcand = 0; ld_count = 0; ld_res = 0;
        drv_sum = 0; drv_zero = 0; drv_opa = 0; count_sel_op = 0;
    endtask

    // Word layout: bits 7:0 accumulator, 15:8 multiplicand, 23:16 counter, 31:24 result.
    task automatic scan_load(input logic [31:0] v);
        scan_en = 1;
        for (int k = 0; k < 32; k++) begin
            scan_in = v[31-k];
            cycle();
        end
        scan_en = 0;
        scan_in = 0;
    endtask

    // Reads the chain with the output looped back, so the contents survive.
    task automatic scan_dump(output logic [31:0] v);
        scan_en = 1;
        for (int k = 0; k < 32; k++) begin
            v[31-k] = scan_out;
            scan_in = scan_out;
            cycle();
        end
        scan_en = 0;
        scan_in = 0;
    endtask

    task automatic bus_to_acc_op(input logic [7:0] v);
        idle(); drv_opa = 1; opa = v; ld_acc = 1; cycle(); idle();
    endtask

    task automatic bus_to_mcand_op(input logic [7:0] v);
        idle(); drv_opa = 1; opa = v; ld_mcand = 1; cycle(); idle();
    endtask

    task automatic sum_to_res();
        idle(); drv_sum = 1; ld_res = 1; cycle(); idle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 result after reset", {24'b0, result}, 32'h00);
        check("R1 underflow after reset", {31'b0, count_underflow}, 32'h1);
        scan_dump(v);
        check("R1 chain after reset", v, 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        idle(); count_sel_op = 1; opb = 8'h03; ld_count = 1; cycle(); idle();
        check("R4 underflow clear for count 3", {31'b0, count_underflow}, 32'h0);
        scan_dump(v);
        check("R2 counter field after load", {24'b0, v[23:16]}, 32'h03);
        for (int k = 1; k <= 3; k++) begin
            idle(); ld_count = 1; count_sel_op = 0; cycle(); idle();
            check("R4 underflow while counting down", {31'b0, count_underflow},
                  (k == 3) ? 32'h1 : 32'h0);
        end
        idle(); ld_count = 1; count_sel_op = 0; cycle(); idle();
        check("R3 underflow after wrap", {31'b0, count_underflow}, 32'h0);
        scan_dump(v);
        check("R3 counter wraps 00 to FF", {24'b0, v[23:16]}, 32'hFF);
    endtask

    task automatic t_bus();
        bus_to_acc_op(8'h3C); bus_to_mcand_op(8'h0F); sum_to_res();
        check("R5 operand loads and sum", {24'b0, result}, 32'h4B);
        check("R8 scan_out equals result msb (0)", {31'b0, scan_out}, 32'h0);
        bus_to_acc_op(8'hF0); bus_to_mcand_op(8'h20); sum_to_res();
        check("R5 sum wraps modulo 256", {24'b0, result}, 32'h10);
        bus_to_acc_op(8'h90); bus_to_mcand_op(8'h05); sum_to_res();
        check("R5 sum 90+05", {24'b0, result}, 32'h95);
        check("R8 scan_out equals result msb (1)", {31'b0, scan_out}, 32'h1);
        idle(); drv_zero = 1; ld_acc = 1; cycle(); idle(); sum_to_res();
        check("R5 zero driver clears accumulator", {24'b0, result}, 32'h05);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        scan_load(32'h9A05_2144);
        idle(); drv_opa = 1; opa = 8'hFF; count_sel_op = 0; cycle(); cycle();
        idle(); drv_sum = 1; count_sel_op = 1; opb = 8'h77; cycle(); idle();
        scan_dump(v);
        check("R6 all registers hold with loads low", v, 32'h9A05_2144);
    endtask

    task automatic t_scan();
        logic [31:0] v;
        ld_acc = 1; ld_mcand = 1; ld_count = 1; ld_res = 1;
        drv_opa = 1; opa = 8'hFF; count_sel_op = 1; opb = 8'hEE;
        scan_load(32'h5603_3412);
        idle();
        check("R7 result field from chain positions 24-31", {24'b0, result}, 32'h56);
        check("R7 counter field nonzero", {31'b0, count_underflow}, 32'h0);
        sum_to_res();
        check("R7 acc and mcand fields from positions 0-15", {24'b0, result}, 32'h46);
        scan_dump(v);
        check("R7 chain contents after loads ignored", v, 32'h4603_3412);
    endtask

    task automatic t_no_driver();
        bus_to_acc_op(8'h77);
        idle(); ld_acc = 1; opa = 8'hFF; cycle(); idle();
        idle(); drv_zero = 1; ld_mcand = 1; cycle(); idle();
        sum_to_res();
        check("R10 undriven bus loads zero", {24'b0, result}, 32'h00);
    endtask

    task automatic t_multiply(input logic [7:0] x, input logic [7:0] y);
        logic [15:0] p;
        int guard;
        p = x * y;
        idle(); drv_zero = 1; ld_acc = 1; cycle(); idle();
        drv_opa = 1; opa = x; ld_mcand = 1; count_sel_op = 1; opb = y; ld_count = 1;
        cycle(); idle();
        guard = 0;
        while (!count_underflow && guard < 300) begin
            ld_count = 1; count_sel_op = 0; drv_sum = 1; ld_acc = 1;
            cycle();
            guard++;
        end
        idle(); drv_zero = 1; ld_mcand = 1; cycle(); idle();
        sum_to_res();
        check($sformatf("R9 product %0d*%0d", x, y), {24'b0, result}, {24'b0, p[7:0]});
        check($sformatf("R9 loop count for %0d", y), guard, {24'b0, y});
    endtask

    task automatic t_async_reset();
        bus_to_acc_op(8'h11); bus_to_mcand_op(8'h22); sum_to_res();
        idle(); count_sel_op = 1; opb = 8'h09; ld_count = 1; cycle(); idle();
        rst_n = 0;
        #1;
        check("R1 async reset clears result", {24'b0, result}, 32'h00);
        check("R1 async reset sets underflow", {31'b0, count_underflow}, 32'h1);
        @(negedge clk);
        rst_n = 1;
        cycle();
    endtask

    initial begin
        rst_n = 0; scan_in = 0; opa = 0; opb = 0;
        idle();
        repeat (2) @(negedge clk);
        rst_n = 1;
        cycle();
        t_reset();
        t_count();
        t_bus();
        t_hold();
        t_scan();
        t_no_driver();
        t_multiply(8'd3, 8'd7);
        t_multiply(8'd13, 8'd11);
        t_multiply(8'd0, 8'd9);
        t_multiply(8'd9, 8'd0);
        t_multiply(8'd25, 8'd12);
        t_async_reset();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule